// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Recognizer

This block watches a single-bit serial stream, taking one bit on each rising clock edge. It flags every occurrence of the pattern 1101 in that stream. The flag is a Mealy output: it is a combinational function of the current state and the bit now on the input. It is therefore high during the same cycle in which the closing 1 of the pattern is presented, before the edge that consumes that bit.

Matches may overlap. The closing 1 of one match is also taken as the first 1 of the next, so the stream 1101101 yields two flags. The machine has four states, which stand for "nothing useful seen", "1 seen", "11 seen" and "110 seen". They are held in two flip-flops with a Gray-style code, and an asynchronous active-high reset returns the machine to its idle state.

Top module: `patt_recog_1101`

## Requirements
- R1: While `rst` is high, `hit_o` is 0 whatever `ser_in` carries. Raising `rst` at any moment discards all history, so the three bits before a reset can never be combined with a bit after it to form a match.
- R2: `hit_o` is 1 in a cycle exactly when `ser_in` is 1 in that cycle and the three bits sampled just before it, since the last reset, were 1, 1, 0 in arrival order.
- R3: A match's closing 1 counts as the first bit of a following match (overlap). The stream 1101101 gives flags on bits 4 and 7, counting from 1.
- R4: A run of three or more 1s keeps the "11 seen" meaning. The stream 11101 gives exactly one flag, on bit 5.
- R5: After a match, a 0 followed by a 1 does not re-arm toward a second match. The stream 110101 gives exactly one flag, on bit 4.
- R6: `hit_o` is 0 in every cycle where `ser_in` is 0.
- R7: `hit_o` is never high in two consecutive clock cycles.
- R8: Over a long random stream, `hit_o` matches a sliding four-bit window reference in every cycle.
- R9: State code (high bit, low bit): idle 00, "1" 01, "11" 11, "110" 10. The next low bit always equals the sampled input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `ser_in` is sampled on each edge |
| rst | input | 1 | Asynchronous active-high reset to the idle state |
| ser_in | input | 1 | Serial data bit |
| hit_o | output | 1 | Combinational match flag for the bit now on `ser_in` |

## Verification
The hardest case to create from the ports is a reset that lands while the machine is in its "110 seen" state with a 1 already on the input. At that moment the flag would be high but for the reset, and the history must be thrown away. The stimulus drives 1, 1, 0 and then, mid-cycle, puts a 1 on the input and raises reset in the same step. It checks that the flag stays low, then releases reset and sends a lone 1 to confirm that no stale history produces a match. Overlap and runs of ones are covered by directed streams. A long random stream is then compared bit by bit with a four-bit sliding-window model.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;
    localparam int STATE_W = 2;

    // Gray-style code; neighbouring states on the main path differ in one bit
    typedef enum logic [STATE_W-1:0] {
        S_IDLE      = 2'b00,
        S_GOT1      = 2'b01,
        S_GOT11     = 2'b11,
        S_GOT110    = 2'b10
    } rec_state_e;

    typedef struct packed {
        rec_state_e state;
    } rec_regs_t;

    localparam rec_regs_t REGS_RESET = '{state: S_IDLE};
endpackage

// File: rtl/seqrec_next.sv
module seqrec_next
    import seqrec_pkg::*;
#(
    parameter bit EQN_FORM = 1'b1   // 1: reduced equations, 0: explicit table
) (
    input  rec_state_e cur_state,
    input  logic       bit_in,
    output rec_state_e nxt_state
);
    generate
        if (EQN_FORM) begin : g_eqn
            logic hi, lo, hi_d, lo_d;
            always_comb begin
                hi   = cur_state[1];
                lo   = cur_state[0];
                lo_d = bit_in;
                hi_d = (hi & lo) | (bit_in & lo);
                nxt_state = rec_state_e'({hi_d, lo_d});
            end
        end else begin : g_tbl
            always_comb begin
                unique case (cur_state)
                    S_IDLE:   nxt_state = bit_in ? S_GOT1  : S_IDLE;
                    S_GOT1:   nxt_state = bit_in ? S_GOT11 : S_IDLE;
                    S_GOT11:  nxt_state = bit_in ? S_GOT11 : S_GOT110;
                    S_GOT110: nxt_state = bit_in ? S_GOT1  : S_IDLE;
                    default:  nxt_state = S_IDLE;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/seqrec_out.sv
module seqrec_out
    import seqrec_pkg::*;
(
    input  rec_state_e cur_state,
    input  logic       bit_in,
    output logic       hit
);
    always_comb begin
        hit = bit_in & cur_state[1] & ~cur_state[0];
    end
endmodule

// File: rtl/patt_recog_1101.sv
module patt_recog_1101
    import seqrec_pkg::*;
#(
    parameter bit EQN_FORM = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    output logic hit_o
);
    rec_regs_t  regs_d, regs_q;
    rec_state_e nxt_state;
    rec_state_e state_q;
    logic       hit_raw;

    assign state_q = regs_q.state;

    seqrec_next #(.EQN_FORM(EQN_FORM)) u_next (
        .cur_state (state_q),
        .bit_in    (ser_in),
        .nxt_state (nxt_state)
    );

    seqrec_out u_out (
        .cur_state (state_q),
        .bit_in    (ser_in),
        .hit       (hit_raw)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) regs_q <= REGS_RESET;
        else     regs_q <= regs_d;
    end

    assign hit_o = hit_raw & ~rst;
endmodule

// File: rtl/seqrec_chk.sv
module seqrec_chk
    import seqrec_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ser_in,
    input logic       hit_o,
    input rec_state_e state_q
);
    // independent sliding window of bits seen since reset
    logic [2:0] hist_q;
    logic [1:0] seen_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hist_q <= 3'b000;
            seen_q <= 2'd0;
        end else begin
            hist_q <= {hist_q[1:0], ser_in};
            if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
        end
    end

    always @(negedge clk) begin
        if (rst) a_r1_quiet_in_reset: assert (!hit_o);
    end

    a_r6_zero_input_no_hit: assert property (@(posedge clk) disable iff (rst)
        !ser_in |-> !hit_o);

    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);

    a_r3_hit_leaves_got1: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> (state_q == S_GOT1));

    a_r4_ones_hold_got11: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_GOT11 && ser_in) |=> (state_q == S_GOT11));

    a_r9_low_bit_follows_input: assert property (@(posedge clk) disable iff (rst)
        ser_in |=> state_q[0]);

    a_r2_window_match: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd3) |-> (hit_o == (hist_q == 3'b110 && ser_in)));
endmodule

bind patt_recog_1101 seqrec_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .hit_o   (hit_o),
    .state_q (state_q)
);

// File: tb/sim_patt_recog_1101.sv
`timescale 1ns/1ps
module sim_patt_recog_1101;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic hit_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [2:0] win;     // reference window, newest bit in [0]
    int         nseen;

    always #2 clk = ~clk;   // 250 MHz

    patt_recog_1101 u0 (.clk(clk), .rst(rst), .ser_in(ser_in), .hit_o(hit_o));

    task automatic chk(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: hit_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ref_clear();
        win = 3'b000;
        nseen = 0;
    endtask

    function automatic logic ref_hit(input logic b);
        return (nseen >= 3) && (win == 3'b110) && b;
    endfunction

    // drive one bit at negedge, check combinational flag, consume at posedge
    task automatic send(input logic b, input logic exp, input string req);
        @(negedge clk);
        ser_in = b;
        #1;
        chk(hit_o, exp, req);
        if (!b) chk(hit_o, 1'b0, "R6");
        @(posedge clk);
        win = {win[1:0], b};
        nseen++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ser_in = 1'b1;
        #1;
        chk(hit_o, 1'b0, "R1 reset level");
        @(negedge clk);
        rst = 1'b0;
        ser_in = 1'b0;
        ref_clear();
    endtask

    task automatic run_seq(input logic [15:0] bits, input logic [15:0] exp,
                           input int n, input string req);
        do_reset();
        for (int i = n - 1; i >= 0; i--) begin
            send(bits[i], exp[i], req);
        end
    endtask

    task automatic t_reset_midstream();
        do_reset();
        send(1'b1, 1'b0, "R1 prefix");
        send(1'b1, 1'b0, "R1 prefix");
        send(1'b0, 1'b0, "R1 prefix");
        @(negedge clk);
        ser_in = 1'b1;
        rst = 1'b1;
        #1;
        chk(hit_o, 1'b0, "R1 async reset in got110");
        @(negedge clk);
        rst = 1'b0;
        ref_clear();
        send(1'b1, 1'b0, "R1 history cleared");
        send(1'b0, 1'b0, "R1 history cleared");
    endtask

    task automatic t_overlap();
        run_seq(16'b1101101, 16'b0001001, 7, "R3 overlap 1101101");
    endtask

    task automatic t_run_of_ones();
        run_seq(16'b11101, 16'b00001, 5, "R4 run 11101");
        run_seq(16'b1111101, 16'b0000001, 7, "R4 run 1111101");
    endtask

    task automatic t_no_rearm();
        run_seq(16'b110101, 16'b000100, 6, "R5 110101");
    endtask

    task automatic t_basic();
        run_seq(16'b1101, 16'b0001, 4, "R2 single 1101");
        run_seq(16'b0110100, 16'b0000100, 7, "R2 padded");
        run_seq(16'b1011, 16'b0000, 4, "R2 near miss 1011");
    endtask

    task automatic t_random();
        logic prev_hit;
        do_reset();
        prev_hit = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            logic b;
            logic e;
            b = 1'($urandom_range(0, 1));
            e = ref_hit(b);
            @(negedge clk);
            ser_in = b;
            #1;
            chk(hit_o, e, "R8 random vs window");
            if (prev_hit) chk(hit_o, 1'b0, "R7 no back-to-back");
            prev_hit = hit_o;
            @(posedge clk);
            win = {win[1:0], b};
            nseen++;
        end
    endtask

    initial begin
        void'($urandom(32'h1101));
        ref_clear();
        repeat (2) @(posedge clk);
        #1;
        chk(hit_o, 1'b0, "R1 initial reset");
        t_basic();
        t_overlap();
        t_run_of_ones();
        t_no_rearm();
        t_reset_midstream();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule